// File: doc/BRIEF.md
# Staged DAC Channel Register Bank

This block holds the per-channel settings for a bank of analog output channels. Each channel has four writable fields: a sample code, a full-scale range selector, a signed fine-gain trim and a signed offset trim. Range, fine-gain and offset writes act at once. Sample codes go into a holding register first and reach the output only when a bank-wide load command arrives. The load updates every channel in the same clock cycle, so a downstream serializer sees one coherent set of codes.

Software reaches the bank through a single-cycle write port and a combinational read port. The address has three parts: a control flag in the top bit, a channel index, and a two-bit field selector in the low bits. A write to the control location carries two one-shot commands, load and clear. Both are write-only and read back as zero. Reset first forces all outputs to midscale with neutral trims, so that codes pass through uncorrected. The asynchronous reset is then released in step with the clock.

Top module: `dacbank_regs`

## Requirements
- R1: After reset, every holding and active code is 0x8000 (midscale of the 16-bit offset-binary code), and every range code, fine-gain trim and offset trim reads 0.
- R2: A write with wr_addr[5]=0 and field wr_addr[1:0]=0 stores wr_data in the holding register of channel wr_addr[4:2]. A read of that address then returns the stored value. dac_code does not change until a load.
- R3: A write to the control location (wr_addr[5]=1) with wr_data[0]=1 (load) copies every channel's holding code to dac_code in the same cycle. Channel k occupies dac_code[16k+15:16k].
- R4: A control write with wr_data[1]=1 (clear) sets every holding code to 0x0000 and leaves dac_code unchanged.
- R5: When load and clear are in the same control write, the clear is applied first, and every dac_code lane becomes 0x0000.
- R6: Any read with rd_addr[5]=1 returns 0, including just after a load or clear is written.
- R7: Field 1 stores a 2-bit range code (0: ±10 V, 1: ±10.2564 V, 2: ±10.5263 V), which reads back as written. dac_range[2k+1:2k] shows the code, except that the spare code 3 is shown as 0.
- R8: Field 2 stores wr_data[5:0] as a two's-complement fine-gain trim (−32..+31 LSB). It appears on dac_fine[6k+5:6k] on the next cycle without a load, and reads back zero-extended.
- R9: Field 3 stores wr_data[7:0] as a two's-complement offset trim in eighth-LSB steps (−16..+15.875 LSB). It appears on dac_offset[8k+7:8k] on the next cycle without a load, and reads back zero-extended.
- R10: A write changes only the addressed field of the addressed channel. With wr_en low, no register changes, whatever wr_addr and wr_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 6 | Write address: control flag, channel, field |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read address, same layout as wr_addr |
| rd_data | output | 16 | Combinational read data |
| dac_code | output | 128 | Active 16-bit code per channel |
| dac_range | output | 16 | Range selector per channel, spare code folded |
| dac_fine | output | 48 | Fine-gain trim per channel |
| dac_offset | output | 64 | Offset trim per channel |

## Verification
The bench writes data codes without a load and watches for any movement on dac_code. A design without the holding stage would pass each new code straight through. It sends clear on its own, where a design that also cleared the active stage would zero the outputs too early. It sends clear and load together, where applying them in the wrong order would load stale codes instead of zeros. It also writes the spare range code, signed trim extremes and idle cycles with changing address and data, which expose a missing fold, a truncated field or a write that fires without its strobe.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

  localparam int RANGE_W = 2;

  typedef enum logic [1:0] {
    FLD_CODE  = 2'd0,
    FLD_RANGE = 2'd1,
    FLD_FINE  = 2'd2,
    FLD_OFFS  = 2'd3
  } field_e;

  localparam int CMD_LOAD_BIT  = 0;
  localparam int CMD_CLEAR_BIT = 1;

  typedef struct packed {
    logic clear;
    logic load;
  } bank_cmd_t;

  // Spare range selector folds onto the narrowest range.
  function automatic logic [RANGE_W-1:0] fold_range(input logic [RANGE_W-1:0] c);
    fold_range = (c == 2'b11) ? 2'b00 : c;
  endfunction

endpackage

// File: rtl/dacbank_rstsync.sv
module dacbank_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      sync_q  <= stage_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/dacbank_decode.sv
module dacbank_decode
  import dacbank_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 3
) (
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [1:0]     wr_cmd_bits,
  output logic [NCH-1:0] ch_we,
  output field_e         wr_field,
  output bank_cmd_t      cmd
);
  logic           ctl_sel;
  logic [CHW-1:0] ch_idx;

  assign ctl_sel  = wr_addr[AW-1];
  assign ch_idx   = wr_addr[AW-2:2];
  assign wr_field = field_e'(wr_addr[1:0]);

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_we
      assign ch_we[gi] = wr_en && !ctl_sel && (ch_idx == CHW'(gi));
    end
  endgenerate

  always_comb begin
    cmd       = '0;
    cmd.load  = wr_en && ctl_sel && wr_cmd_bits[CMD_LOAD_BIT];
    cmd.clear = wr_en && ctl_sel && wr_cmd_bits[CMD_CLEAR_BIT];
  end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan
  import dacbank_pkg::*;
#(
  parameter int DW  = 16,
  parameter int FGW = 6,
  parameter int OFW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  field_e             field,
  input  logic [DW-1:0]      wdata,
  input  bank_cmd_t          cmd,
  output logic [DW-1:0]      hold_code,
  output logic [DW-1:0]      act_code,
  output logic [RANGE_W-1:0] range_code,
  output logic [FGW-1:0]     fine_trim,
  output logic [OFW-1:0]     offs_trim
);
  localparam logic [DW-1:0] MIDSCALE = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0]      hold_q, hold_d, act_q, act_d;
  logic [RANGE_W-1:0] rng_q;
  logic [FGW-1:0]     fine_q;
  logic [OFW-1:0]     offs_q;
  logic               hold_en, act_en, rng_en, fine_en, offs_en;

  always_comb begin
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (cmd.clear) begin
      hold_d  = '0;
      hold_en = 1'b1;
    end else if (we && field == FLD_CODE) begin
      hold_d  = wdata;
      hold_en = 1'b1;
    end
    // Clear takes effect ahead of a coincident load.
    act_en  = cmd.load;
    act_d   = cmd.clear ? '0 : hold_q;
    rng_en  = we && (field == FLD_RANGE);
    fine_en = we && (field == FLD_FINE);
    offs_en = we && (field == FLD_OFFS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= MIDSCALE;
      act_q  <= MIDSCALE;
      rng_q  <= '0;
      fine_q <= '0;
      offs_q <= '0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (act_en)  act_q  <= act_d;
      if (rng_en)  rng_q  <= wdata[RANGE_W-1:0];
      if (fine_en) fine_q <= wdata[FGW-1:0];
      if (offs_en) offs_q <= wdata[OFW-1:0];
    end
  end

  assign hold_code  = hold_q;
  assign act_code   = act_q;
  assign range_code = rng_q;
  assign fine_trim  = fine_q;
  assign offs_trim  = offs_q;
endmodule

// File: rtl/dacbank_rdmux.sv
module dacbank_rdmux
  import dacbank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 16,
  parameter int FGW = 6,
  parameter int OFW = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 3
) (
  input  logic [AW-1:0]          rd_addr,
  input  logic [NCH*DW-1:0]      hold_flat,
  input  logic [NCH*RANGE_W-1:0] range_flat,
  input  logic [NCH*FGW-1:0]     fine_flat,
  input  logic [NCH*OFW-1:0]     offs_flat,
  output logic [DW-1:0]          rd_data
);
  logic [CHW-1:0] idx;
  field_e         fld;

  assign idx = rd_addr[AW-2:2];
  assign fld = field_e'(rd_addr[1:0]);

  always_comb begin
    rd_data = '0;
    if (!rd_addr[AW-1] && (int'(idx) < NCH)) begin
      unique case (fld)
        FLD_CODE:  rd_data = hold_flat[int'(idx)*DW +: DW];
        FLD_RANGE: rd_data = {{(DW-RANGE_W){1'b0}}, range_flat[int'(idx)*RANGE_W +: RANGE_W]};
        FLD_FINE:  rd_data = {{(DW-FGW){1'b0}}, fine_flat[int'(idx)*FGW +: FGW]};
        FLD_OFFS:  rd_data = {{(DW-OFW){1'b0}}, offs_flat[int'(idx)*OFW +: OFW]};
        default:   rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/dacbank_regs.sv
module dacbank_regs
  import dacbank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 16,
  parameter int FGW = 6,
  parameter int OFW = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic [NCH*DW-1:0]      dac_code,
  output logic [NCH*RANGE_W-1:0] dac_range,
  output logic [NCH*FGW-1:0]     dac_fine,
  output logic [NCH*OFW-1:0]     dac_offset
);
  logic                   rst_int_n;
  logic [NCH-1:0]         ch_we;
  field_e                 wr_field;
  bank_cmd_t              cmd;
  logic [NCH*DW-1:0]      hold_flat;
  logic [NCH*RANGE_W-1:0] range_flat;

  dacbank_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dacbank_decode #(.NCH(NCH)) u_dec (
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_cmd_bits (wr_data[1:0]),
    .ch_we       (ch_we),
    .wr_field    (wr_field),
    .cmd         (cmd)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NCH; gc++) begin : g_ch
      dacbank_chan #(.DW(DW), .FGW(FGW), .OFW(OFW)) u_chan (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .we         (ch_we[gc]),
        .field      (wr_field),
        .wdata      (wr_data),
        .cmd        (cmd),
        .hold_code  (hold_flat[gc*DW +: DW]),
        .act_code   (dac_code[gc*DW +: DW]),
        .range_code (range_flat[gc*RANGE_W +: RANGE_W]),
        .fine_trim  (dac_fine[gc*FGW +: FGW]),
        .offs_trim  (dac_offset[gc*OFW +: OFW])
      );
      assign dac_range[gc*RANGE_W +: RANGE_W] = fold_range(range_flat[gc*RANGE_W +: RANGE_W]);
    end
  endgenerate

  dacbank_rdmux #(.NCH(NCH), .DW(DW), .FGW(FGW), .OFW(OFW)) u_rd (
    .rd_addr    (rd_addr),
    .hold_flat  (hold_flat),
    .range_flat (range_flat),
    .fine_flat  (dac_fine),
    .offs_flat  (dac_offset),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/dacbank_regs_chk.sv
module dacbank_regs_chk #(
  parameter int NCH = 8,
  parameter int DW  = 16,
  parameter int FGW = 6,
  parameter int OFW = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 3
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic [AW-1:0]     rd_addr,
  input logic [DW-1:0]     rd_data,
  input logic [NCH*DW-1:0] hold_flat,
  input logic [NCH*DW-1:0] dac_code,
  input logic [NCH*2-1:0]  dac_range,
  input logic [NCH*FGW-1:0] dac_fine
);
  logic ctl_wr, ld_wr, clr_wr;
  assign ctl_wr = wr_en && wr_addr[AW-1];
  assign ld_wr  = ctl_wr && wr_data[0];
  assign clr_wr = ctl_wr && wr_data[1];

  p_code_held_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ld_wr |=> $stable(dac_code));

  p_load_all_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ld_wr && !clr_wr) |=> (dac_code == $past(hold_flat)));

  p_clear_hold_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr_wr |=> (hold_flat == '0));

  p_clear_then_load_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ld_wr && clr_wr) |=> (dac_code == '0));

  p_ctl_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_addr[AW-1] |-> (rd_data == '0));

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      p_range_legal_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
        dac_range[g*2 +: 2] != 2'b11);

      p_range_fold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
        (wr_en && !wr_addr[AW-1] && (int'(wr_addr[AW-2:2]) == g) &&
         (wr_addr[1:0] == 2'd1) && (wr_data[1:0] == 2'b11))
        |=> (dac_range[g*2 +: 2] == 2'b00));

      p_fine_direct_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
        (wr_en && !wr_addr[AW-1] && (int'(wr_addr[AW-2:2]) == g) && (wr_addr[1:0] == 2'd2))
        |=> (dac_fine[g*FGW +: FGW] == $past(wr_data[FGW-1:0])));
    end
  endgenerate
endmodule

bind dacbank_regs dacbank_regs_chk #(.NCH(NCH), .DW(DW), .FGW(FGW), .OFW(OFW)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .hold_flat (hold_flat),
  .dac_code  (dac_code),
  .dac_range (dac_range),
  .dac_fine  (dac_fine)
);

// File: tb/dacbank_regs_tb.sv
module dacbank_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam logic [5:0] CTL = 6'h20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [5:0]    wr_addr;
  logic [15:0]   wr_data;
  logic [5:0]    rd_addr;
  logic [15:0]   rd_data;
  logic [127:0]  dac_code;
  logic [15:0]   dac_range;
  logic [47:0]   dac_fine;
  logic [63:0]   dac_offset;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  // Reference model
  logic [15:0] m_hold [NCH];
  logic [15:0] m_act  [NCH];
  logic [1:0]  m_rng  [NCH];
  logic [5:0]  m_fine [NCH];
  logic [7:0]  m_offs [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dacbank_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dac_code(dac_code), .dac_range(dac_range),
    .dac_fine(dac_fine), .dac_offset(dac_offset)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_hold[i] = 16'h8000; m_act[i] = 16'h8000;
        m_rng[i] = 0; m_fine[i] = 0; m_offs[i] = 0;
      end
    end else if (wr_en) begin
      if (wr_addr[5]) begin
        if (wr_data[1]) for (int i = 0; i < NCH; i++) m_hold[i] = 16'h0000;
        if (wr_data[0]) for (int i = 0; i < NCH; i++) m_act[i] = m_hold[i];
      end else begin
        case (wr_addr[1:0])
          2'd0: m_hold[wr_addr[4:2]] = wr_data;
          2'd1: m_rng[wr_addr[4:2]]  = wr_data[1:0];
          2'd2: m_fine[wr_addr[4:2]] = wr_data[5:0];
          default: m_offs[wr_addr[4:2]] = wr_data[7:0];
        endcase
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison of all parallel outputs.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NCH; i++) begin
        check(cur_req, $sformatf("dac_code ch%0d", i), 32'(dac_code[i*16 +: 16]), 32'(m_act[i]));
        check("R7", $sformatf("dac_range ch%0d", i), 32'(dac_range[i*2 +: 2]),
              32'((m_rng[i] == 2'b11) ? 2'b00 : m_rng[i]));
        check("R8", $sformatf("dac_fine ch%0d", i), 32'(dac_fine[i*6 +: 6]), 32'(m_fine[i]));
        check("R9", $sformatf("dac_offset ch%0d", i), 32'(dac_offset[i*8 +: 8]), 32'(m_offs[i]));
      end
    end
  end

  function automatic logic [5:0] adr(int ch, int fld);
    return {1'b0, 3'(ch), 2'(fld)};
  endfunction

  function automatic logic [15:0] exp_rd(logic [5:0] a);
    if (a[5]) return 16'h0;
    case (a[1:0])
      2'd0: return m_hold[a[4:2]];
      2'd1: return {14'h0, m_rng[a[4:2]]};
      2'd2: return {10'h0, m_fine[a[4:2]]};
      default: return {8'h0, m_offs[a[4:2]]};
    endcase
  endfunction

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_all(string req);
    for (int c = 0; c < NCH; c++) begin
      for (int f = 0; f < 4; f++) begin
        rd_addr = adr(c, f);
        #1;
        check(req, $sformatf("readback ch%0d field%0d", c, f), 32'(rd_data), 32'(exp_rd(rd_addr)));
      end
    end
    rd_addr = CTL;
    #1;
    check("R6", "control readback", 32'(rd_data), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset values
    cur_req = "R1";
    for (int i = 0; i < NCH; i++) check("R1", "reset code", 32'(dac_code[i*16 +: 16]), 32'h8000);
    rd_all("R1");

    // R2: staged data writes, outputs stay put
    cur_req = "R2";
    for (int i = 0; i < NCH; i++) wr(adr(i, 0), 16'h1111 * 16'(i + 1) ^ 16'h0F0F);
    rd_all("R2");

    // R3: simultaneous load
    cur_req = "R3";
    wr(CTL, 16'h0001);
    for (int i = 0; i < NCH; i++)
      check("R3", "loaded lane", 32'(dac_code[i*16 +: 16]), 32'(16'h1111 * 16'(i + 1) ^ 16'h0F0F));
    rd_all("R6");

    // R10: single-channel write touches only that channel
    cur_req = "R10";
    wr(adr(3, 0), 16'hFFFF);
    wr(adr(3, 2), 16'h0015);
    rd_all("R10");

    // R4: clear zeros holding only
    cur_req = "R4";
    wr(CTL, 16'h0002);
    rd_all("R4");
    check("R4", "lane 0 unchanged after clear", 32'(dac_code[15:0]), 32'(16'h1111 ^ 16'h0F0F));

    // R5: clear and load together
    cur_req = "R5";
    for (int i = 0; i < NCH; i++) wr(adr(i, 0), 16'hA5A0 + 16'(i));
    wr(CTL, 16'h0003);
    for (int i = 0; i < NCH; i++) check("R5", "zero lane", 32'(dac_code[i*16 +: 16]), 32'h0);
    rd_all("R5");

    // R7: range codes including the spare one
    cur_req = "R7";
    for (int i = 0; i < NCH; i++) wr(adr(i, 1), 16'(i % 4));
    check("R7", "spare folded ch3", 32'(dac_range[7:6]), 32'h0);
    check("R7", "code 2 ch2", 32'(dac_range[5:4]), 32'h2);
    rd_all("R7");

    // R8 / R9: signed trim extremes
    cur_req = "R8";
    wr(adr(0, 2), 16'hFFE0);  // -32, upper bits ignored
    wr(adr(1, 2), 16'h001F);  // +31
    check("R8", "fine -32", 32'(dac_fine[5:0]), 32'h20);
    cur_req = "R9";
    wr(adr(6, 3), 16'h1280);  // -16 LSB
    wr(adr(7, 3), 16'h007F);  // +15.875 LSB
    check("R9", "offset -16", 32'(dac_offset[55:48]), 32'h80);
    rd_all("R9");

    // R10: idle bus activity with wr_en low
    cur_req = "R10";
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      wr_addr = 6'(k * 5); wr_data = 16'hDEAD ^ 16'(k);
    end
    @(negedge clk);
    rd_all("R10");

    // R6: control reads zero after writing it
    wr(CTL, 16'hFFFF);
    rd_addr = CTL; #1;
    check("R6", "control after all-ones write", 32'(rd_data), 32'h0);
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule